// File: doc/BRIEF.md
# Priority Memory Protection Region Checker

This block decides, for every instruction fetch and every data load or store, whether the access may proceed. It holds two small tables of programmable address regions, one consulted by fetches and one by data accesses. Each region covers a range of 4 KB pages from a base page up to, but not including, a limit page. Each region also carries its own enable bit, per-mode permission bits and, for data regions, a default cacheability bit. Regions may overlap. When several enabled regions contain the address, the one with the lowest index wins outright.

The permit and cacheable answers are combinational from the request port. A denied valid access raises a violation pulse one clock later. The faulting address is latched alongside the pulse, so exception logic can read it as a bad-address value. After reset the checker is switched off and lets everything through. Software turns it on by writing the control field. An access can carry an I/O flag that forces it uncached whatever its region says. A typical use is a small no-access hole placed between stack and heap, at a lower index than the large region around it, so that a stack or heap overflow traps.

Top module: `mpc_guard`

## Requirements
- R1: After reset the checker is disabled, every region in both tables is disabled, `viol_o` is 0 and `viol_addr` is 0.
- R2: While the checker is disabled, every valid access gives `acc_ok`=1 and no violation. `acc_cacheable` is then 1 for a valid data access with `req_io`=0, and 0 otherwise.
- R3: Configuration is written on `cfg_we`. `cfg_dside` chooses the table (1 = data, 0 = instruction) and `cfg_idx` chooses the entry. `cfg_field` selects what is written: 0 = base, 1 = exclusive limit, 2 = attributes, 3 = control. A control write sets the checker enable to `cfg_wdata[0]`, whatever `cfg_dside` and `cfg_idx` hold. Base and limit keep only address bits above bit 11.
- R4: A region matches when its enable bit is set and the address page lies in the range base ≤ page < limit. An address equal to the limit does not match.
- R5: When several enabled regions match, only the lowest-index one decides permission and cacheability.
- R6: The attribute word is laid out as follows. Bit 0 is supervisor read (data) or execute (instruction). Bit 1 is supervisor write. Bit 2 is user read or execute. Bit 3 is user write. Bit 4 is cacheable (data only). Bit 5 is the region enable. `req_user`=1 selects the user bits. A store (`req_kind`=2) checks the write bit. A load (1), a fetch (0) or code 3 checks the read/execute bit.
- R7: A fetch is checked only against the instruction table, and a load or store only against the data table.
- R8: With the checker enabled, a valid access that matches no enabled region is denied.
- R9: With the checker enabled, a valid access whose winning region lacks the needed permission bit is denied. A region whose permission bits are all clear is therefore a no-access hole.
- R10: `acc_cacheable` is 1 only for a permitted data access whose winning region has bit 4 set. A fetch always gives 0.
- R11: `req_io`=1 forces `acc_cacheable` to 0 in every case.
- R12: `viol_o` is 1 in the cycle after a valid denied request, and 0 otherwise. On such a violation `viol_addr` takes that request's address, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dside | input | 1 | Table select: 1 data, 0 instruction |
| cfg_idx | input | IDX_W | Region entry index |
| cfg_field | input | 2 | 0 base, 1 limit, 2 attributes, 3 control |
| cfg_wdata | input | ADDR_W | Write data |
| req_valid | input | 1 | Access request valid |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_io | input | 1 | Uncached I/O access flag |
| req_addr | input | ADDR_W | Access address |
| acc_ok | output | 1 | Access permitted (combinational) |
| acc_cacheable | output | 1 | Access may use the data cache (combinational) |
| viol_o | output | 1 | Region violation, one cycle after the request |
| viol_addr | output | ADDR_W | Address of the last violating access |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, eight entries per table and 4 KB pages. Eight entries are enough to stack an empty hole, a wide region and a lower-priority overlapping region over the same pages. They also leave room for a user-only region and a region whose enable bit is clear. Together these reach the priority, hole, mode-split, exclusive-limit and disabled-entry cases. Using index 7 in the instruction table exercises the top entry of the priority chain.

// File: rtl/mpc_pkg.sv
// Package: shared encodings for the region checker.
// Assumes attribute bits are placed as listed in the brief; other modules rely on this order.
package mpc_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_ATTR  = 2'd2,
        FLD_CTRL  = 2'd3
    } cfg_field_e;

    localparam int ATTR_W = 6;

    // Region attributes, MSB first: enable, cacheable, user write,
    // user read/exec, supervisor write, supervisor read/exec.
    typedef struct packed {
        logic en;
        logic cache;
        logic usr_w;
        logic usr_rx;
        logic sup_w;
        logic sup_rx;
    } region_attr_t;

endpackage

// File: rtl/mpc_region_table.sv
// Module: one table of programmable regions with a page-range match per entry.
// Assumes base and limit are page numbers; the limit is exclusive.
// wr_en is already qualified for this table by the parent.
module mpc_region_table
    import mpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int PN_W  = ADDR_W - PAGE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [1:0]              wr_field,
    input  logic [ADDR_W-1:0]       wr_data,
    input  logic [PN_W-1:0]         look_page,
    output logic [NREG-1:0]         hit_vec,
    output region_attr_t [NREG-1:0] attr_vec
);

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [PN_W-1:0] base_q;
        logic [PN_W-1:0] limit_q;
        region_attr_t    attr_q;
        logic            sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Hold the entry's base, limit and attributes; cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q  <= '0;
                limit_q <= '0;
                attr_q  <= '0;
            end else if (sel) begin
                if (wr_field == FLD_BASE)  base_q  <= wr_data[ADDR_W-1:PAGE_W];
                if (wr_field == FLD_LIMIT) limit_q <= wr_data[ADDR_W-1:PAGE_W];
                if (wr_field == FLD_ATTR)  attr_q  <= region_attr_t'(wr_data[ATTR_W-1:0]);
            end
        end

        // The entry matches when enabled and the page is inside [base, limit).
        always_comb begin
            hit_vec[g] = attr_q.en && (look_page >= base_q) && (look_page < limit_q);
        end

        assign attr_vec[g] = attr_q;
    end

endmodule

// File: rtl/mpc_prio_pick.sv
// Module: fixed-priority picker; the lowest set index in hit_vec wins.
// Assumes NREG >= 2.
module mpc_prio_pick #(
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  hit_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx
);

    // Scan from the top down so the lowest index is the last to overwrite.
    always_comb begin
        win_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
        any_hit = |hit_vec;
    end

endmodule

// File: rtl/mpc_perm_eval.sv
// Module: turns the winning region's attributes into the permit and cacheable answers.
// Assumes attr is meaningful only when hit is 1.
module mpc_perm_eval
    import mpc_pkg::*;
(
    input  logic         chk_en,
    input  logic         valid,
    input  logic [1:0]   kind,
    input  logic         user,
    input  logic         io,
    input  logic         hit,
    input  region_attr_t attr,
    output logic         permit,
    output logic         cacheable
);

    logic is_data;
    logic need_bit;

    // Pick the permission bit that this access kind and mode require.
    always_comb begin
        is_data = (kind != ACC_FETCH);
        if (kind == ACC_STORE) need_bit = user ? attr.usr_w  : attr.sup_w;
        else                   need_bit = user ? attr.usr_rx : attr.sup_rx;
    end

    // Resolve permit and cacheability, with a bypass when the checker is off.
    always_comb begin
        if (!chk_en) begin
            permit    = valid;
            cacheable = valid && is_data && !io;
        end else begin
            permit    = valid && hit && need_bit;
            cacheable = permit && is_data && !io && attr.cache;
        end
    end

endmodule

// File: rtl/mpc_guard.sv
// Module: top of the region checker. Holds the enable bit and both region
// tables, resolves each access, and registers violations with their address.
// Assumes synchronous active-low reset and a single request per cycle.
module mpc_guard
    import mpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int PN_W  = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_dside,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              acc_ok,
    output logic              acc_cacheable,
    output logic [ADDR_W-1:0] viol_addr,
    output logic              viol_o
);

    logic                    enable_q;
    logic                    tbl_wr;
    logic                    iwr_en;
    logic                    dwr_en;
    logic [PN_W-1:0]         page;
    logic [NREG-1:0]         ihit_vec;
    logic [NREG-1:0]         dhit_vec;
    region_attr_t [NREG-1:0] iattr_vec;
    region_attr_t [NREG-1:0] dattr_vec;
    logic                    i_any;
    logic                    d_any;
    logic [IDX_W-1:0]        i_win;
    logic [IDX_W-1:0]        d_win;
    logic                    sel_hit;
    region_attr_t            sel_attr;
    logic                    permit;
    logic                    cacheable;
    logic                    viol_q;
    logic [ADDR_W-1:0]       bad_q;

    // Route table writes to the selected side; control writes go elsewhere.
    always_comb begin
        tbl_wr = cfg_we && (cfg_field != FLD_CTRL);
        iwr_en = tbl_wr && !cfg_dside;
        dwr_en = tbl_wr &&  cfg_dside;
        page   = req_addr[ADDR_W-1:PAGE_W];
    end

    // Checker enable: off after reset, set by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                             enable_q <= 1'b0;
        else if (cfg_we && cfg_field == FLD_CTRL) enable_q <= cfg_wdata[0];
    end

    mpc_region_table #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NREG(NREG)) u_itbl (
        .clk(clk), .rst_n(rst_n), .wr_en(iwr_en), .wr_idx(cfg_idx),
        .wr_field(cfg_field), .wr_data(cfg_wdata), .look_page(page),
        .hit_vec(ihit_vec), .attr_vec(iattr_vec)
    );

    mpc_region_table #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NREG(NREG)) u_dtbl (
        .clk(clk), .rst_n(rst_n), .wr_en(dwr_en), .wr_idx(cfg_idx),
        .wr_field(cfg_field), .wr_data(cfg_wdata), .look_page(page),
        .hit_vec(dhit_vec), .attr_vec(dattr_vec)
    );

    mpc_prio_pick #(.NREG(NREG)) u_ipick (
        .hit_vec(ihit_vec), .any_hit(i_any), .win_idx(i_win)
    );

    mpc_prio_pick #(.NREG(NREG)) u_dpick (
        .hit_vec(dhit_vec), .any_hit(d_any), .win_idx(d_win)
    );

    // Fetches consult the instruction table, everything else the data table.
    always_comb begin
        if (req_kind == ACC_FETCH) begin
            sel_hit  = i_any;
            sel_attr = iattr_vec[i_win];
        end else begin
            sel_hit  = d_any;
            sel_attr = dattr_vec[d_win];
        end
    end

    mpc_perm_eval u_eval (
        .chk_en(enable_q), .valid(req_valid), .kind(req_kind), .user(req_user),
        .io(req_io), .hit(sel_hit), .attr(sel_attr),
        .permit(permit), .cacheable(cacheable)
    );

    // Register a denied valid access and capture its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            bad_q  <= '0;
        end else begin
            viol_q <= req_valid && !permit;
            if (req_valid && !permit) bad_q <= req_addr;
        end
    end

    assign acc_ok        = permit;
    assign acc_cacheable = cacheable;
    assign viol_o        = viol_q;
    assign viol_addr     = bad_q;

endmodule

// File: rtl/mpc_guard_chk.sv
// Module: property checker attached to mpc_guard through bind.
// Assumes it sees the top ports plus the internal enable bit.
module mpc_guard_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              req_io,
    input logic [ADDR_W-1:0] req_addr,
    input logic              acc_ok,
    input logic              acc_cacheable,
    input logic              viol_o,
    input logic [ADDR_W-1:0] viol_addr
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!viol_o && !en && viol_addr == '0));

    // R2
    disabled_permits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && req_valid) |-> acc_ok);

    // R10
    fetch_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |-> !acc_cacheable);

    // R11
    io_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_io |-> !acc_cacheable);

    // R12
    viol_follows_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc_ok) |=> viol_o);

    // R12
    viol_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(req_valid && !acc_ok));

    // R12
    bad_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_addr == $past(req_addr)));

    // R12
    bad_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_o |-> $stable(viol_addr));

endmodule

bind mpc_guard mpc_guard_chk #(.ADDR_W(ADDR_W)) u_guard_chk (
    .clk(clk), .rst_n(rst_n), .en(enable_q), .req_valid(req_valid),
    .req_kind(req_kind), .req_io(req_io), .req_addr(req_addr),
    .acc_ok(acc_ok), .acc_cacheable(acc_cacheable),
    .viol_o(viol_o), .viol_addr(viol_addr)
);

// File: tb/mpc_guard_bench.sv
// Bench: scoreboard driven. The driver checks the combinational answers and
// queues the expected violation state; the monitor compares it a cycle later.
module mpc_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int NREG       = 8;
    localparam int IDX_W      = $clog2(NREG);

    typedef struct {
        logic        viol;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic              cfg_dside = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [1:0]        cfg_field = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = '0;
    logic              req_user = 1'b0;
    logic              req_io = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              acc_ok;
    logic              acc_cacheable;
    logic [ADDR_W-1:0] viol_addr;
    logic              viol_o;

    int   checks = 0;
    int   failures = 0;
    exp_t sb_q[$];
    logic [31:0] last_bad = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpc_guard #(.ADDR_W(ADDR_W), .NREG(NREG)) u_mpc_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dside(cfg_dside),
        .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_user(req_user),
        .req_io(req_io), .req_addr(req_addr), .acc_ok(acc_ok),
        .acc_cacheable(acc_cacheable), .viol_addr(viol_addr), .viol_o(viol_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic dside, input int idx,
                             input logic [1:0] fld, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_dside = dside;
        cfg_idx   = IDX_W'(idx);
        cfg_field = fld;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Drive one request, check the immediate answers, queue the violation item.
    task automatic issue(input string req, input logic v, input logic [1:0] k,
                         input logic u, input logic io, input logic [31:0] a,
                         input logic eok, input logic ecache);
        exp_t it;
        @(negedge clk);
        req_valid = v;
        req_kind  = k;
        req_user  = u;
        req_io    = io;
        req_addr  = a;
        #1;
        check(req, "acc_ok", {31'd0, acc_ok}, {31'd0, eok});
        check(req, "acc_cacheable", {31'd0, acc_cacheable}, {31'd0, ecache});
        it.viol = v && !eok;
        if (it.viol) last_bad = a;
        it.addr = last_bad;
        it.tag  = req;
        sb_q.push_back(it);
    endtask

    // Monitor: one cycle after each request, compare the registered violation.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check({it.tag, "/R12"}, "viol_o", {31'd0, viol_o}, {31'd0, it.viol});
                check({it.tag, "/R12"}, "viol_addr", viol_addr, it.addr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, checker disabled so a request passes.
        req_valid = 1'b1;
        req_kind  = 2'd1;
        req_addr  = 32'h0000_2800;
        repeat (3) @(negedge clk);
        check("R1", "viol_o", {31'd0, viol_o}, 32'd0);
        check("R1", "viol_addr", viol_addr, 32'd0);
        check("R1", "acc_ok", {31'd0, acc_ok}, 32'd1);
        rst_n     = 1'b1;
        req_valid = 1'b0;

        // R3: data table setup (field codes 0 base, 1 limit, 2 attr).
        cfg_write(1, 0, 2'd0, 32'h0000_2000);  // hole
        cfg_write(1, 0, 2'd1, 32'h0000_3000);
        cfg_write(1, 0, 2'd2, 32'h0000_0020);
        cfg_write(1, 1, 2'd0, 32'h0000_0000);  // wide, sup RW user R, cached
        cfg_write(1, 1, 2'd1, 32'h0001_0000);
        cfg_write(1, 1, 2'd2, 32'h0000_0037);
        cfg_write(1, 2, 2'd0, 32'h0000_2000);  // overlapping, uncached, all RW
        cfg_write(1, 2, 2'd1, 32'h0000_4000);
        cfg_write(1, 2, 2'd2, 32'h0000_002F);
        cfg_write(1, 3, 2'd0, 32'h0002_0ABC);  // low bits dropped
        cfg_write(1, 3, 2'd1, 32'h0002_1000);
        cfg_write(1, 3, 2'd2, 32'h0000_002C);  // user RW only
        cfg_write(1, 4, 2'd0, 32'h0003_0000);
        cfg_write(1, 4, 2'd1, 32'h0003_1000);
        cfg_write(1, 4, 2'd2, 32'h0000_001F);  // enable bit clear
        cfg_write(0, 0, 2'd0, 32'h0000_0000);  // instr: sup exec
        cfg_write(0, 0, 2'd1, 32'h0000_8000);
        cfg_write(0, 0, 2'd2, 32'h0000_0021);
        cfg_write(0, 7, 2'd0, 32'h0000_8000);  // instr: sup+user exec
        cfg_write(0, 7, 2'd1, 32'h0000_9000);
        cfg_write(0, 7, 2'd2, 32'h0000_0025);

        // R2: still disabled, so the hole and the I/O flag decide nothing else.
        issue("R2", 1, 2'd1, 1, 0, 32'h0000_2800, 1, 1);
        issue("R2", 1, 2'd2, 1, 1, 32'h0000_2800, 1, 0);
        issue("R2", 1, 2'd0, 1, 0, 32'h0000_2800, 1, 0);

        cfg_write(1, 5, 2'd3, 32'h0000_0001);  // R3: control write enables

        issue("R6", 1, 2'd1, 0, 0, 32'h0000_1000, 1, 1);
        issue("R9", 1, 2'd2, 1, 0, 32'h0000_1000, 0, 0);
        issue("R10", 1, 2'd1, 1, 0, 32'h0000_1000, 1, 1);
        issue("R9", 1, 2'd1, 0, 0, 32'h0000_2800, 0, 0);   // hole wins
        issue("R5", 1, 2'd1, 0, 0, 32'h0000_3800, 1, 1);   // region 1 over 2
        issue("R11", 1, 2'd1, 0, 1, 32'h0000_3800, 1, 0);
        issue("R4", 1, 2'd2, 1, 0, 32'h0002_0FFC, 1, 0);
        issue("R6", 1, 2'd2, 0, 0, 32'h0002_0FFC, 0, 0);
        issue("R4", 1, 2'd1, 1, 0, 32'h0002_1000, 0, 0);   // limit exclusive
        issue("R8", 1, 2'd1, 0, 0, 32'h0003_0000, 0, 0);   // disabled entry
        issue("R7", 1, 2'd0, 0, 0, 32'h0000_0100, 1, 0);
        issue("R6", 1, 2'd0, 1, 0, 32'h0000_0100, 0, 0);
        issue("R5", 1, 2'd0, 1, 0, 32'h0000_8004, 1, 0);
        issue("R7", 1, 2'd0, 0, 0, 32'h0002_0000, 0, 0);   // data region only
        issue("R12", 0, 2'd1, 0, 0, 32'h0000_2800, 0, 0);  // invalid: no pulse

        cfg_write(0, 2, 2'd3, 32'h0000_0000);  // R3: disable again
        issue("R2", 1, 2'd1, 1, 0, 32'h0000_2800, 1, 1);
        issue("R2", 1, 2'd0, 1, 0, 32'h0000_0100, 1, 0);

        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule